// File: doc/BRIEF.md
# Two-Bank DRAM Command Timing Monitor

This block listens passively to the command pins of a synchronous graphics DRAM that has two internal banks. On every rising clock edge it decodes the command on the bus and keeps a record of which banks hold an open row. For each bank it counts the cycles that have passed since that bank was activated. It checks each command against the device's state and timing rules, and it reports every broken rule on a flag of its own.

The timing limits are parameters given in whole clock cycles. To get each value, divide the nanosecond figure by the clock period and round up. The monitor also keeps a copy of the programmed mode fields (burst length, burst type, read latency and write burst length), so that logic nearby can follow the device's configuration.

Each rule has a one-cycle pulse bit and a sticky bit. Both are registered, so the bits for a command show up one clock after the command is sampled. Only a synchronous reset clears the sticky bits.

Top module: `sgram_cmd_monitor`

## Requirements
- R1: A mode write is decoded only when csN, rasN, casN, weN and dsfN are all low, and cke is high in both this cycle and the previous one. When the write is accepted it loads burstLen=addr[2:0], burstType=addr[3], readLat=addr[6:4] and writeBurst=addr[9], and it sets modeValid.
- R2: A mode write with any of addr[7], addr[8] or addr[10] set raises violation bit 1.
- R3: A mode write while any bank is active raises violation bit 0 and leaves the stored mode fields unchanged.
- R4: An activate, read or write decoded while modeValid is low raises violation bit 2.
- R5: Activate is encoded as csN=0, rasN=0, casN=1, weN=1, dsfN=0, with the bank chosen by bankSel. An activate to a bank that is already active raises violation bit 3 and changes no bank state. Two activates to the same bank are never checked for bank spacing.
- R6: Read is encoded as csN=0, rasN=1, casN=0, weN=1, dsfN=0, and write is the same with weN=0. A read or write to an active bank fewer than TRCD cycles after that bank's activate raises violation bit 4.
- R7: An activate of the other bank fewer than TRRD cycles after the last accepted activate raises violation bit 5.
- R8: A precharge that closes an active bank fewer than TRAS_MIN cycles after that bank's activate raises violation bit 6.
- R9: A bank that is still active TRAS_MAX+1 cycles after its activate raises violation bit 7. A bank precharged at TRAS_MAX cycles or sooner does not.
- R10: violPulse shows the violations of the command sampled at the previous edge, for one cycle only. violSticky ORs in every pulse and keeps its bits until reset.
- R11: Precharge is encoded as csN=0, rasN=0, casN=1, weN=0, dsfN=0. It closes the bank chosen by bankSel, or both banks when addr[10]=1. bankActive reports which banks are open.
- R12: A synchronous reset clears all flags, closes both banks and clears modeValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable pin |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| dsfN | input | 1 | Special-function pin, low for normal commands |
| bankSel | input | 1 | Bank address |
| addr | input | 11 | Address pins |
| violPulse | output | 8 | Per-rule violation pulse, one cycle |
| violSticky | output | 8 | Per-rule accumulated violations |
| bankActive | output | 2 | Open-row state per bank |
| modeValid | output | 1 | A mode write has been accepted |
| burstLen | output | 3 | Stored burst length code |
| burstType | output | 1 | Stored burst type |
| readLat | output | 3 | Stored read latency code |
| writeBurst | output | 1 | Stored write burst length select |

## Verification
A wrong bank state or a wrong age count shows up as a false or missing pulse at the first command that checks it. Sweeping the spacing between commands across each threshold exposes an off-by-one in a counter at exactly one distance. The tRAS-max check looks at the age of an open bank on every cycle, so a stuck age counter is revealed within TRAS_MAX+1 cycles, even when no further command arrives. A corrupted mode copy becomes visible one cycle after the write that loads it.

// File: rtl/sgram_mon_pkg.sv
package sgram_mon_pkg;
  localparam int NB = 2;
  localparam int NV = 8;

  localparam int V_MRS_BUSY = 0;
  localparam int V_MRS_RSV  = 1;
  localparam int V_UNPROG   = 2;
  localparam int V_ACT_BUSY = 3;
  localparam int V_RCD      = 4;
  localparam int V_RRD      = 5;
  localparam int V_RAS_MIN  = 6;
  localparam int V_RAS_MAX  = 7;

  typedef struct packed {
    logic          mrsLoad;
    logic [NB-1:0] actLoad;
    logic          actAny;
    logic          actBank;
    logic [NV-1:0] violSet;
  } monStrobes_t;
endpackage

// File: rtl/sgram_mon_ctrl.sv
module sgram_mon_ctrl
  import sgram_mon_pkg::*;
#(
  parameter int TRCD     = 3,
  parameter int TRRD     = 2,
  parameter int TRAS_MIN = 5,
  parameter int TRAS_MAX = 20,
  parameter int AW       = 6,
  parameter int RW       = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cke,
  input  logic                   csN,
  input  logic                   rasN,
  input  logic                   casN,
  input  logic                   weN,
  input  logic                   dsfN,
  input  logic                   bankSel,
  input  logic [2:0]             rsvBits,
  input  logic [NB-1:0][AW-1:0]  bankAge,
  input  logic [RW-1:0]          sinceAct,
  input  logic                   lastActBank,
  input  logic                   anyAct,
  input  logic                   modeValid,
  output logic [NB-1:0]          bankActive,
  output monStrobes_t            strobes
);
  logic ckePrev;
  logic sel, isMrs, isAct, isRd, isWr, isPre;
  logic [NB-1:0] preHit;
  logic [NV-1:0] violSet;

  always_ff @(posedge clk) begin
    if (rst) ckePrev <= 1'b0;
    else     ckePrev <= cke;
  end

  always_comb begin
    sel   = cke & ~csN & ~dsfN;
    isMrs = sel & ckePrev & ~rasN & ~casN & ~weN;
    isAct = sel & ~rasN &  casN &  weN;
    isRd  = sel &  rasN & ~casN &  weN;
    isWr  = sel &  rasN & ~casN & ~weN;
    isPre = sel & ~rasN &  casN & ~weN;
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign preHit[b] = isPre & (rsvBits[2] | (bankSel == 1'(b)));

    always_ff @(posedge clk) begin
      if (rst)                    bankActive[b] <= 1'b0;
      else if (strobes.actLoad[b]) bankActive[b] <= 1'b1;
      else if (preHit[b])          bankActive[b] <= 1'b0;
    end
  end

  always_comb begin
    violSet = '0;
    violSet[V_MRS_BUSY] = isMrs & (|bankActive);
    violSet[V_MRS_RSV]  = isMrs & (|rsvBits);
    violSet[V_UNPROG]   = (isAct | isRd | isWr) & ~modeValid;
    violSet[V_ACT_BUSY] = isAct & bankActive[bankSel];
    violSet[V_RCD]      = (isRd | isWr) & bankActive[bankSel] &
                          (bankAge[bankSel] < AW'(TRCD));
    violSet[V_RRD]      = isAct & anyAct & (bankSel != lastActBank) &
                          (sinceAct < RW'(TRRD));
    for (int b = 0; b < NB; b++) begin
      if (preHit[b] && bankActive[b] && (bankAge[b] < AW'(TRAS_MIN)))
        violSet[V_RAS_MIN] = 1'b1;
      if (bankActive[b] && (bankAge[b] == AW'(TRAS_MAX + 1)))
        violSet[V_RAS_MAX] = 1'b1;
    end
  end

  always_comb begin
    strobes.mrsLoad = isMrs & ~(|bankActive);
    for (int b = 0; b < NB; b++)
      strobes.actLoad[b] = isAct & (bankSel == 1'(b)) & ~bankActive[b];
    strobes.actAny  = isAct & ~bankActive[bankSel];
    strobes.actBank = bankSel;
    strobes.violSet = violSet;
  end

  // R11
  pre_all_chk: assert property (@(posedge clk) disable iff (rst)
    (isPre && rsvBits[2]) |=> (bankActive == '0));

  // R5
  act_busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (isAct && bankActive[bankSel]) |=> $stable(bankActive));
endmodule

// File: rtl/sgram_mon_dpath.sv
module sgram_mon_dpath
  import sgram_mon_pkg::*;
#(
  parameter int AW = 6,
  parameter int RW = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  monStrobes_t           strobes,
  input  logic [7:0]            modeBits,
  output logic [NB-1:0][AW-1:0] bankAge,
  output logic [RW-1:0]         sinceAct,
  output logic                  lastActBank,
  output logic                  anyAct,
  output logic                  modeValid,
  output logic [2:0]            burstLen,
  output logic                  burstType,
  output logic [2:0]            readLat,
  output logic                  writeBurst,
  output logic [NV-1:0]         violPulse,
  output logic [NV-1:0]         violSticky
);
  for (genvar b = 0; b < NB; b++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst)                      bankAge[b] <= '0;
      else if (strobes.actLoad[b])  bankAge[b] <= AW'(1);
      else if (bankAge[b] != '1)    bankAge[b] <= bankAge[b] + 1'b1;
    end

    // R6
    age_start_chk: assert property (@(posedge clk) disable iff (rst)
      strobes.actLoad[b] |=> (bankAge[b] == AW'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceAct    <= '0;
      lastActBank <= 1'b0;
      anyAct      <= 1'b0;
    end else if (strobes.actAny) begin
      sinceAct    <= RW'(1);
      lastActBank <= strobes.actBank;
      anyAct      <= 1'b1;
    end else if (sinceAct != '1) begin
      sinceAct    <= sinceAct + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeValid  <= 1'b0;
      burstLen   <= '0;
      burstType  <= 1'b0;
      readLat    <= '0;
      writeBurst <= 1'b0;
    end else if (strobes.mrsLoad) begin
      modeValid  <= 1'b1;
      burstLen   <= modeBits[2:0];
      burstType  <= modeBits[3];
      readLat    <= modeBits[6:4];
      writeBurst <= modeBits[7];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      violPulse  <= '0;
      violSticky <= '0;
    end else begin
      violPulse  <= strobes.violSet;
      violSticky <= violSticky | strobes.violSet;
    end
  end

  // R10
  sticky_cover_chk: assert property (@(posedge clk) disable iff (rst)
    ((violPulse & ~violSticky) == '0));

  // R10
  sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((violSticky & $past(violSticky)) == $past(violSticky)));

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strobes.mrsLoad)) |->
      $stable({modeValid, burstLen, burstType, readLat, writeBurst}));
endmodule

// File: rtl/sgram_cmd_monitor.sv
module sgram_cmd_monitor
  import sgram_mon_pkg::*;
#(
  parameter int TRCD     = 3,
  parameter int TRRD     = 2,
  parameter int TRAS_MIN = 5,
  parameter int TRAS_MAX = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cke,
  input  logic        csN,
  input  logic        rasN,
  input  logic        casN,
  input  logic        weN,
  input  logic        dsfN,
  input  logic        bankSel,
  input  logic [10:0] addr,
  output logic [7:0]  violPulse,
  output logic [7:0]  violSticky,
  output logic [1:0]  bankActive,
  output logic        modeValid,
  output logic [2:0]  burstLen,
  output logic        burstType,
  output logic [2:0]  readLat,
  output logic        writeBurst
);
  localparam int AW = $clog2(TRAS_MAX + 2) + 1;
  localparam int RW = $clog2(TRRD + 1) + 1;

  monStrobes_t           strobes;
  logic [NB-1:0][AW-1:0] bankAge;
  logic [RW-1:0]         sinceAct;
  logic                  lastActBank;
  logic                  anyAct;

  sgram_mon_ctrl #(
    .TRCD(TRCD), .TRRD(TRRD), .TRAS_MIN(TRAS_MIN), .TRAS_MAX(TRAS_MAX),
    .AW(AW), .RW(RW)
  ) ctrl_i (
    .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .dsfN(dsfN), .bankSel(bankSel),
    .rsvBits({addr[10], addr[8], addr[7]}),
    .bankAge(bankAge), .sinceAct(sinceAct), .lastActBank(lastActBank),
    .anyAct(anyAct), .modeValid(modeValid),
    .bankActive(bankActive), .strobes(strobes)
  );

  sgram_mon_dpath #(.AW(AW), .RW(RW)) dpath_i (
    .clk(clk), .rst(rst), .strobes(strobes),
    .modeBits({addr[9], addr[6:0]}),
    .bankAge(bankAge), .sinceAct(sinceAct), .lastActBank(lastActBank),
    .anyAct(anyAct), .modeValid(modeValid), .burstLen(burstLen),
    .burstType(burstType), .readLat(readLat), .writeBurst(writeBurst),
    .violPulse(violPulse), .violSticky(violSticky)
  );
endmodule

// File: tb/sgram_cmd_monitor_tb_top.sv
module sgram_cmd_monitor_tb_top;
  localparam int TRCD = 3, TRRD = 2, TRAS_MIN = 5, TRAS_MAX = 20;
  localparam int K_MRS = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4;

  logic clk = 1'b0;
  logic rst, cke, csN, rasN, casN, weN, dsfN, bankSel;
  logic [10:0] addr;
  logic [7:0] violPulse, violSticky;
  logic [1:0] bankActive;
  logic modeValid, burstType, writeBurst;
  logic [2:0] burstLen, readLat;
  int nChecks = 0, nFails = 0;

  always #4 clk = ~clk;

  sgram_cmd_monitor #(.TRCD(TRCD), .TRRD(TRRD), .TRAS_MIN(TRAS_MIN),
                      .TRAS_MAX(TRAS_MAX)) dut_i (
    .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .dsfN(dsfN), .bankSel(bankSel), .addr(addr),
    .violPulse(violPulse), .violSticky(violSticky), .bankActive(bankActive),
    .modeValid(modeValid), .burstLen(burstLen), .burstType(burstType),
    .readLat(readLat), .writeBurst(writeBurst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input int kind, input logic bk, input logic [10:0] a);
    csN = 1'b0; dsfN = 1'b0; bankSel = bk; addr = a;
    case (kind)
      K_MRS:   {rasN, casN, weN} = 3'b000;
      K_ACT:   {rasN, casN, weN} = 3'b011;
      K_RD:    {rasN, casN, weN} = 3'b101;
      K_WR:    {rasN, casN, weN} = 3'b100;
      default: {rasN, casN, weN} = 3'b010;
    endcase
    @(negedge clk);
    csN = 1'b1; {rasN, casN, weN} = 3'b111;
  endtask

  task automatic doReset();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic startUp();
    doReset();
    cmd(K_MRS, 1'b0, 11'h000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rst = 1'b1; cke = 1'b1; csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
    dsfN = 1'b1; bankSel = 1'b0; addr = '0;
    @(negedge clk);
    doReset();
    // R12 reset state
    chk("R12 sticky", violSticky, 0);
    chk("R12 banks", bankActive, 0);
    chk("R12 modeValid", modeValid, 0);

    // R4 access before programming
    cmd(K_ACT, 1'b0, 11'h000);
    chk("R4 act unprogrammed", violPulse[2], 1);
    cmd(K_RD, 1'b0, 11'h000);
    chk("R4 read unprogrammed", violPulse[2], 1);
    idle(3);
    chk("R10 pulse cleared", violPulse, 0);
    chk("R10 sticky kept", violSticky[2], 1);

    // R1 mode write needs cke high in the previous cycle
    doReset();
    cke = 1'b0; idle(1); cke = 1'b1;
    cmd(K_MRS, 1'b0, 11'h007);
    chk("R1 cke low before write", modeValid, 0);
    cmd(K_MRS, 1'b0, 11'h007);
    chk("R1 accepted", modeValid, 1);

    // R1 field capture sweep
    for (int v = 0; v < 256; v++) begin
      cmd(K_MRS, 1'b0, {1'b0, v[7], 2'b00, v[6:0]});
      chk("R1 fields", {writeBurst, readLat, burstType, burstLen}, v);
    end
    chk("R1 no flags", violSticky, 0);

    // R2 reserved bits
    for (int r = 0; r < 8; r++) begin
      cmd(K_MRS, 1'b0, {r[2], 1'b0, r[1], r[0], 7'h00});
      chk("R2 reserved", violPulse[1], (r != 0));
    end

    // R3 mode write while active
    startUp();
    cmd(K_ACT, 1'b1, 11'h000);
    cmd(K_MRS, 1'b0, 11'h07F);
    chk("R3 busy flag", violPulse[0], 1);
    chk("R3 fields kept", {readLat, burstType, burstLen}, 0);

    // R5 activate busy bank
    startUp();
    cmd(K_ACT, 1'b0, 11'h000);
    cmd(K_ACT, 1'b0, 11'h000);
    chk("R5 act busy", violPulse[3], 1);
    chk("R5 same bank no spacing flag", violPulse[5], 0);
    chk("R5 state unchanged", bankActive, 2'b01);

    // R6 activate-to-access sweep
    for (int d = 1; d <= TRCD + 2; d++) begin
      for (int w = 0; w < 2; w++) begin
        startUp();
        cmd(K_ACT, 1'(d), 11'h000);
        idle(d - 1);
        cmd(w ? K_WR : K_RD, 1'(d), 11'h000);
        chk("R6 rcd", violPulse[4], (d < TRCD));
      end
    end

    // R7 cross-bank activate spacing sweep
    for (int d = 1; d <= TRRD + 2; d++) begin
      startUp();
      cmd(K_ACT, 1'b0, 11'h000);
      idle(d - 1);
      cmd(K_ACT, 1'b1, 11'h000);
      chk("R7 rrd", violPulse[5], (d < TRRD));
    end

    // R8 minimum active time sweep, single and all-bank precharge
    for (int d = 1; d <= TRAS_MIN + 2; d++) begin
      for (int all = 0; all < 2; all++) begin
        startUp();
        cmd(K_ACT, 1'b0, 11'h000);
        idle(d - 1);
        cmd(K_PRE, 1'b0, {1'(all), 10'h000});
        chk("R8 ras min", violPulse[6], (d < TRAS_MIN));
        chk("R11 closed", bankActive, 0);
      end
    end

    // R9 maximum active time sweep
    for (int d = TRAS_MAX - 1; d <= TRAS_MAX + 2; d++) begin
      startUp();
      cmd(K_ACT, 1'b1, 11'h000);
      idle(d - 1);
      cmd(K_PRE, 1'b1, 11'h000);
      idle(2);
      chk("R9 ras max", violSticky[7], (d > TRAS_MAX));
      chk("R10 pulse one cycle", violPulse, 0);
    end

    // R11 per-bank and all-bank precharge
    startUp();
    cmd(K_ACT, 1'b0, 11'h000);
    idle(TRRD - 1);
    cmd(K_ACT, 1'b1, 11'h000);
    chk("R11 both open", bankActive, 2'b11);
    cmd(K_PRE, 1'b0, 11'h000);
    chk("R11 single close", bankActive, 2'b10);
    cmd(K_ACT, 1'b0, 11'h000);
    cmd(K_PRE, 1'b0, 11'h400);
    chk("R11 all close", bankActive, 2'b00);

    // R12 reset during activity
    cmd(K_ACT, 1'b0, 11'h000);
    doReset();
    chk("R12 sticky cleared", violSticky, 0);
    chk("R12 banks cleared", bankActive, 0);
    chk("R12 mode cleared", modeValid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule